// File: doc/BRIEF.md
# Arm Hit Width Discriminator with Gated Multiplicity

This block sits at the front of one arm of a two-arm interaction trigger. It receives the discriminated hit lines of a group of detector channels (five by default) and samples each one on a fast clock. A channel pulse becomes a valid hit only when it stays high for longer than a programmable number of samples. Each valid hit then fires a shaped pulse of programmable, fixed length. A per-channel enable mask selects which channels take part. The shaped pulses of enabled channels are ORed into the arm timing pulse, so the rising edge of that pulse marks the earliest accepted hit.

The first valid hit on an enabled channel opens a counting gate of programmable length. Over that gate the block records which enabled channels produced a valid hit. It counts each channel at most once. When the gate closes, the hit pattern word and its multiplicity are offered on a valid/ready result port.

Back-pressure rules: `res_valid` stays high with `res_mult` and `res_pattern` stable until a cycle in which `res_ready` is also high. While a result is waiting, no new gate opens and valid hits are not counted. The timing pulse keeps running during that time.

Top module: `arm_hit_trigger`

## Requirements
- R1: After reset, `timing_out`, `res_valid`, `res_mult` and `res_pattern` are all zero.
- R2: A channel pulse is accepted only if it is high for more than `width_thr` consecutive samples. A pulse of `width_thr` samples or fewer causes no timing pulse and no count.
- R3: For an isolated accepted pulse whose first high sample is taken at clock edge s, `timing_out` goes high after edge s+`width_thr`+2 and stays high for exactly `shape_len` cycles. One pulse yields one shaped pulse, however long it lasts.
- R4: `chan_enable` bit i set to 1 enables channel i. A disabled channel drives no timing pulse, opens no gate and is never counted.
- R5: A gate opens on the first accepted enabled hit while no result is waiting. It includes hits accepted at that edge and at the `gate_len`+1 edges that follow. An accepted hit after that starts a new gate.
- R6: In the result, `res_pattern` bit i (bit 0 = channel 0) is 1 exactly when channel i gave an accepted hit inside the gate. `res_mult` equals the number of set bits, so a channel is counted once even if it fires twice.
- R7: While `res_valid` is high and `res_ready` is low, the result stays unchanged and hits open no gate. `timing_out` still reflects those hits.
- R8: `width_thr` and `shape_len` may be changed at runtime. Pulses that start after a change use the new values.
- R9: Whenever `res_valid` is high, `res_mult` is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_in | input | N_CH | Discriminated hit line per channel |
| width_thr | input | THR_W | Pulse width that must be exceeded, in samples |
| shape_len | input | SHAPE_W | Length of the shaped pulse, in cycles |
| chan_enable | input | N_CH | Per-channel enable mask, 1 = channel takes part |
| gate_len | input | GATE_W | Extra gate length after the opening hit |
| timing_out | output | 1 | OR of the enabled shaped pulses, registered |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts result |
| res_mult | output | $clog2(N_CH+1) | Number of channels hit in the gate |
| res_pattern | output | N_CH | Channels hit in the gate |

## Verification
Pulses of exactly the threshold width and of one sample more separate rejection from acceptance. A very long pulse shows that the shaped length does not follow the input width. A disabled channel with a wide pulse must leave every output quiet. A channel that fires twice inside one gate must show up once in the pattern word. Hits placed at the last edge of the gate and at the first edge after it mark the window boundary. Seeded random pulse trains with random thresholds, masks and gate lengths are compared with a bench model of the result sequence, and a directed run with `res_ready` held low checks that the waiting result stays put while the timing pulse keeps firing.

// File: rtl/arm_trig_pkg.sv
`timescale 1ns/1ps
package arm_trig_pkg;
  typedef enum logic {
    GATE_IDLE = 1'b0,
    GATE_OPEN = 1'b1
  } gate_state_e;
endpackage

// File: rtl/hit_qualifier.sv
`timescale 1ns/1ps
// Registers one raw hit line and raises fire for one cycle on the sample
// that makes the run of consecutive high samples exceed the threshold.
module hit_qualifier #(
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw_in,
  input  logic [THR_W-1:0] thr_len,
  output logic             fire
);
  localparam int RUN_W = THR_W + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic             in_q;
  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q    <= 1'b0;
      run_cnt <= '0;
    end else begin
      in_q <= raw_in;
      if (!in_q)
        run_cnt <= '0;
      else if (run_cnt != RUN_MAX)
        run_cnt <= run_cnt + 1'b1;
    end
  end

  // run_cnt holds the earlier high samples; in_q is the current one.
  assign fire = in_q && (run_cnt == {1'b0, thr_len});
endmodule

// File: rtl/pulse_shaper.sv
`timescale 1ns/1ps
// Fixed-length pulse generator, restarted by every trigger.
module pulse_shaper #(
  parameter int SHAPE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig,
  input  logic [SHAPE_W-1:0] shape_len,
  output logic               shaped
);
  logic [SHAPE_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)
      left <= '0;
    else if (trig)
      left <= shape_len;
    else if (left != '0)
      left <= left - 1'b1;
  end

  assign shaped = (left != '0);
endmodule

// File: rtl/event_gate.sv
`timescale 1ns/1ps
// Counting gate: opens on the first enabled hit, ORs hits into a pattern,
// and presents pattern and multiplicity on a valid/ready result port.
module event_gate
  import arm_trig_pkg::*;
#(
  parameter int N_CH   = 5,
  parameter int GATE_W = 6,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   qual,
  input  logic [GATE_W-1:0] gate_len,
  input  logic              res_ready,
  output logic              res_valid,
  output logic [CNT_W-1:0]  res_mult,
  output logic [N_CH-1:0]   res_pattern
);
  gate_state_e       state;
  logic [GATE_W-1:0] remain;
  logic [N_CH-1:0]   seen;
  logic [N_CH-1:0]   seen_next;
  logic [CNT_W-1:0]  seen_cnt;
  logic              slot_free;

  assign seen_next = seen | qual;
  assign slot_free = !res_valid || res_ready;

  always_comb begin
    seen_cnt = '0;
    for (int i = 0; i < N_CH; i++)
      seen_cnt = seen_cnt + CNT_W'(seen_next[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= GATE_IDLE;
      remain      <= '0;
      seen        <= '0;
      res_valid   <= 1'b0;
      res_mult    <= '0;
      res_pattern <= '0;
    end else begin
      if (res_valid && res_ready)
        res_valid <= 1'b0;
      case (state)
        GATE_IDLE: begin
          if ((|qual) && slot_free) begin
            state  <= GATE_OPEN;
            remain <= gate_len;
            seen   <= qual;
          end
        end
        GATE_OPEN: begin
          seen <= seen_next;
          if (remain == '0) begin
            state       <= GATE_IDLE;
            res_valid   <= 1'b1;
            res_pattern <= seen_next;
            res_mult    <= seen_cnt;
          end else begin
            remain <= remain - 1'b1;
          end
        end
        default: state <= GATE_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/arm_hit_trigger.sv
`timescale 1ns/1ps
module arm_hit_trigger #(
  parameter int N_CH    = 5,
  parameter int THR_W   = 4,
  parameter int SHAPE_W = 4,
  parameter int GATE_W  = 6,
  localparam int CNT_W  = $clog2(N_CH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_CH-1:0]    hit_in,
  input  logic [THR_W-1:0]   width_thr,
  input  logic [SHAPE_W-1:0] shape_len,
  input  logic [N_CH-1:0]    chan_enable,
  input  logic [GATE_W-1:0]  gate_len,
  output logic               timing_out,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [CNT_W-1:0]   res_mult,
  output logic [N_CH-1:0]    res_pattern
);
  logic [N_CH-1:0] fire_vec;
  logic [N_CH-1:0] shaped_vec;
  logic [N_CH-1:0] qual_en;

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    hit_qualifier #(.THR_W(THR_W)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_in  (hit_in[c]),
      .thr_len (width_thr),
      .fire    (fire_vec[c])
    );
    pulse_shaper #(.SHAPE_W(SHAPE_W)) u_shape (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig      (fire_vec[c]),
      .shape_len (shape_len),
      .shaped    (shaped_vec[c])
    );
  end

  assign qual_en = fire_vec & chan_enable;

  always_ff @(posedge clk) begin
    if (!rst_n)
      timing_out <= 1'b0;
    else
      timing_out <= |(shaped_vec & chan_enable);
  end

  event_gate #(.N_CH(N_CH), .GATE_W(GATE_W), .CNT_W(CNT_W)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .qual        (qual_en),
    .gate_len    (gate_len),
    .res_ready   (res_ready),
    .res_valid   (res_valid),
    .res_mult    (res_mult),
    .res_pattern (res_pattern)
  );
endmodule

// File: rtl/arm_hit_trigger_chk.sv
`timescale 1ns/1ps
module arm_hit_trigger_chk #(
  parameter int N_CH  = 5,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             timing_out,
  input logic [N_CH-1:0]  shaped_vec,
  input logic [N_CH-1:0]  chan_enable,
  input logic             res_valid,
  input logic             res_ready,
  input logic [CNT_W-1:0] res_mult,
  input logic [N_CH-1:0]  res_pattern
);
  // R4: timing only follows a shaped pulse of an enabled channel
  assert_timing_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timing_out |-> $past(|(shaped_vec & chan_enable)));

  // R7: a waiting result holds still
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_mult) && $stable(res_pattern)));

  // R6: multiplicity agrees with the pattern word
  assert_mult_pattern_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (32'(res_mult) == $countones(res_pattern)));

  // R9: an offered result never reports zero hits
  assert_mult_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_mult != '0));
endmodule

bind arm_hit_trigger arm_hit_trigger_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .timing_out  (timing_out),
  .shaped_vec  (shaped_vec),
  .chan_enable (chan_enable),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_mult    (res_mult),
  .res_pattern (res_pattern)
);

// File: tb/arm_hit_trigger_bench.sv
`timescale 1ns/1ps
module arm_hit_trigger_bench;
  localparam int N = 5, TW = 4, SW = 4, GW = 6;
  localparam int CW = $clog2(N + 1);
  localparam int TAIL = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic [N-1:0] hit_in, chan_enable, res_pattern;
  logic [TW-1:0] width_thr;
  logic [SW-1:0] shape_len;
  logic [GW-1:0] gate_len;
  logic timing_out, res_valid, res_ready;
  logic [CW-1:0] res_mult;

  arm_hit_trigger #(.N_CH(N), .THR_W(TW), .SHAPE_W(SW), .GATE_W(GW)) u_arm_hit_trigger (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .width_thr(width_thr),
    .shape_len(shape_len), .chan_enable(chan_enable), .gate_len(gate_len),
    .timing_out(timing_out), .res_valid(res_valid), .res_ready(res_ready),
    .res_mult(res_mult), .res_pattern(res_pattern));

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [N-1:0] wv [0:127];
  int got_m[$], got_p[$], exp_m[$], exp_p[$];
  int tim_first, tim_cnt;

  task automatic chk(string what, bit ok, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  always @(negedge clk)
    if (rst_n && res_valid && res_ready) begin
      got_m.push_back(int'(res_mult));
      got_p.push_back(int'(res_pattern));
    end

  task automatic clear_wave();
    for (int t = 0; t < 128; t++) wv[t] = '0;
  endtask

  task automatic add_pulse(int ch, int s, int w);
    for (int t = s; t < s + w && t < 128; t++) wv[t][ch] = 1'b1;
  endtask

  // Model from the requirements: accepted at the sample completing thr+1 highs,
  // gate window of gate_len+2 acceptance edges, ready assumed high.
  task automatic model(int len);
    int run [N];
    logic [N-1:0] q;
    bit open;
    int endt;
    logic [N-1:0] seen;
    exp_m.delete(); exp_p.delete();
    for (int c = 0; c < N; c++) run[c] = 0;
    open = 0; endt = 0; seen = '0;
    for (int t = 0; t < len + TAIL; t++) begin
      q = '0;
      for (int c = 0; c < N; c++) begin
        if (t < len && wv[t][c]) run[c]++; else run[c] = 0;
        if (run[c] == int'(width_thr) + 1) q[c] = 1'b1;
      end
      q = q & chan_enable;
      if (!open) begin
        if (q != '0) begin open = 1; seen = q; endt = t + int'(gate_len) + 1; end
      end else begin
        seen = seen | q;
        if (t == endt) begin
          open = 0;
          exp_m.push_back($countones(seen));
          exp_p.push_back(int'(seen));
        end
      end
    end
  endtask

  task automatic run_wave(int len);
    tim_first = -1; tim_cnt = 0;
    got_m.delete(); got_p.delete();
    for (int t = 0; t < len + TAIL; t++) begin
      @(negedge clk);
      if (timing_out) begin
        tim_cnt++;
        if (tim_first < 0) tim_first = t;
      end
      hit_in = (t < len) ? wv[t] : '0;
    end
  endtask

  task automatic compare(string tag);
    chk({tag, " result count"}, got_m.size() == exp_m.size(), got_m.size(), exp_m.size());
    for (int i = 0; i < exp_m.size() && i < got_m.size(); i++) begin
      chk({tag, " R6 mult"}, got_m[i] == exp_m[i], got_m[i], exp_m[i]);
      chk({tag, " R6 pattern"}, got_p[i] == exp_p[i], got_p[i], exp_p[i]);
      chk({tag, " R9 nonzero"}, got_m[i] != 0, got_m[i], 1);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; hit_in = '0; res_ready = 1;
    width_thr = 4'd6; shape_len = 4'd5; gate_len = 6'd4; chan_enable = 5'b11111;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 timing_out after reset", timing_out == 0, timing_out, 0);
    chk("R1 res_valid after reset", res_valid == 0, res_valid, 0);
    chk("R1 res_mult after reset", res_mult == 0, res_mult, 0);
    chk("R1 res_pattern after reset", res_pattern == 0, res_pattern, 0);

    // R2: exactly threshold width is rejected
    clear_wave(); add_pulse(0, 2, 6); model(24); run_wave(24);
    chk("R2 width=thr no timing", tim_first == -1, tim_first, -1);
    chk("R2 width=thr no result", got_m.size() == 0, got_m.size(), 0);

    // R2/R3: one sample more is accepted; timing delay and length
    clear_wave(); add_pulse(0, 2, 7); model(24); run_wave(24);
    chk("R3 timing first edge", tim_first == 2 + 6 + 3, tim_first, 11);
    chk("R3 timing length", tim_cnt == 5, tim_cnt, 5);
    chk("R2 accepted pattern", got_p.size() == 1 && got_p[0] == 1, got_p.size(), 1);
    compare("R2 thr+1");

    // R3: long pulse still gives a single shaped pulse
    clear_wave(); add_pulse(2, 1, 30); model(40); run_wave(40);
    chk("R3 long pulse length", tim_cnt == 5, tim_cnt, 5);
    compare("R3 long");

    // R4: disabled channel is invisible
    chan_enable = 5'b11011;
    clear_wave(); add_pulse(2, 1, 12); model(24); run_wave(24);
    chk("R4 disabled no timing", tim_first == -1, tim_first, -1);
    chk("R4 disabled no result", got_m.size() == 0, got_m.size(), 0);
    chan_enable = 5'b11111;

    // R6: channel firing twice counted once
    gate_len = 6'd10;
    clear_wave(); add_pulse(1, 0, 7); add_pulse(1, 9, 7); add_pulse(3, 3, 8);
    model(24); run_wave(24);
    chk("R6 double fire pattern", got_p.size() == 1 && got_p[0] == 5'b01010, got_p.size() ? got_p[0] : -1, 10);
    chk("R6 double fire mult", got_m.size() == 1 && got_m[0] == 2, got_m.size() ? got_m[0] : -1, 2);

    // R5: gate boundary, last edge inside and first edge outside
    gate_len = 6'd3;
    clear_wave(); add_pulse(0, 0, 7); add_pulse(1, 4, 7); add_pulse(2, 5, 7);
    model(24); run_wave(24);
    chk("R5 two gates", got_m.size() == 2, got_m.size(), 2);
    if (got_m.size() == 2) begin
      chk("R5 first gate pattern", got_p[0] == 5'b00011, got_p[0], 3);
      chk("R5 second gate pattern", got_p[1] == 5'b00100, got_p[1], 4);
    end

    // R8: runtime change of threshold and shaper length
    width_thr = 4'd2; shape_len = 4'd9;
    clear_wave(); add_pulse(4, 1, 3); model(24); run_wave(24);
    chk("R8 new thr first edge", tim_first == 1 + 2 + 3, tim_first, 6);
    chk("R8 new shape length", tim_cnt == 9, tim_cnt, 9);
    compare("R8");

    // R7: back-pressure holds result, blocks gate, timing keeps running
    width_thr = 4'd6; shape_len = 4'd5; gate_len = 6'd2;
    @(posedge clk); #1 res_ready = 0;
    clear_wave(); add_pulse(0, 0, 8); add_pulse(1, 20, 8);
    run_wave(40);
    chk("R7 timing during pending", tim_cnt == 10, tim_cnt, 10);
    chk("R7 result held valid", res_valid == 1, res_valid, 1);
    chk("R7 result held pattern", res_pattern == 5'b00001, res_pattern, 1);
    chk("R7 nothing transferred", got_m.size() == 0, got_m.size(), 0);
    @(posedge clk); #1 res_ready = 1;
    repeat (12) @(negedge clk);
    chk("R7 one result after release", got_p.size() == 1, got_p.size(), 1);
    if (got_p.size() == 1) chk("R7 released pattern", got_p[0] == 1, got_p[0], 1);
    chk("R7 blocked hit not counted", res_valid == 0, res_valid, 0);

    // Random batches against the model
    void'($urandom(32'hA5C3));
    for (int b = 0; b < 40; b++) begin
      width_thr = TW'(2 + $urandom_range(6));
      shape_len = SW'(1 + $urandom_range(7));
      gate_len = GW'($urandom_range(10));
      chan_enable = N'($urandom_range(31));
      clear_wave();
      for (int c = 0; c < N; c++)
        for (int k = 0; k < int'($urandom_range(2)); k++)
          add_pulse(c, $urandom_range(30), 1 + $urandom_range(11));
      model(48); run_wave(48);
      compare("R5 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule